// File: doc/BRIEF.md
# Descriptor Chain Walker

The walker follows a linked chain of three-word buffer descriptors kept in a word-wide synchronous memory. It reads each descriptor's control word and buffer pointer, then delivers that buffer's bytes one at a time on a valid/ready byte stream. Only after the last byte has gone out does it read the descriptor's link word, and it then moves on to the descriptor that word names. A chain has no terminal entry. A descriptor may point back to itself or to any earlier one, so a pair of empty descriptors can circle forever as an idle filler.

When a descriptor with the end-of-frame flag finishes, the walker sets a sticky status bit and records that descriptor's address. Software uses the recorded address to find the idle loop and rewrites a link word to splice in fresh data. The walker picks up the new link on its next pass.

A start pulse begins a walk at a given descriptor address. A stop pulse abandons the walk.

States: `ST_IDLE` waits for start. `ST_CTRL_RD` reads the control word. `ST_CTRL_TAKE` decodes it and reads the buffer pointer. `ST_BUF_TAKE` latches the pointer. `ST_WORD_RD` and `ST_WORD_TAKE` fetch the memory word that holds the next byte. `ST_SEND` presents bytes. `ST_LINK_RD` and `ST_LINK_TAKE` read the link word and close the descriptor.

Transitions:
- `ST_IDLE`→`ST_CTRL_RD` on start.
- `ST_CTRL_RD`→`ST_CTRL_TAKE`→`ST_BUF_TAKE`.
- `ST_BUF_TAKE`→`ST_WORD_RD` when the length is non-zero, else →`ST_LINK_RD`.
- `ST_WORD_RD`→`ST_WORD_TAKE`→`ST_SEND`.
- `ST_SEND` stays put until a byte is accepted. After an accepted byte it goes →`ST_LINK_RD` if that was the last byte, →`ST_WORD_RD` if the byte was the top lane of its word, and otherwise stays in `ST_SEND`.
- `ST_LINK_RD`→`ST_LINK_TAKE`→`ST_CTRL_RD`.
- From any busy state, stop →`ST_IDLE`.

Top module: `chain_walker`

## Requirements
- R1: After reset the walker is idle: `busy`, `out_valid`, `mem_rd`, `irq_status` and `irq` are 0, and `eof_desc_addr` is 0.
- R2: The cycle after a start pulse in idle, the walker reads the control word at the descriptor address. The next cycle it reads the buffer pointer at descriptor address + 4. Every memory read uses a word-aligned address.
- R3: In the control word, only the data length (bits 23:12) and the end-of-frame flag (bit 30) have any effect. Bits 11:0, 29:24 and 31 are ignored.
- R4: The walker streams exactly data-length bytes, starting at the buffer pointer, in ascending address order. The pointer may have any byte alignment. The byte at address a sits in bits 8*(a mod 4)+7:8*(a mod 4) of its memory word.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold steady (unless stop is pulsed).
- R6: A descriptor with data length 0 produces no bytes, and the walker goes straight on to its link.
- R7: The link word (descriptor address + 8) is read only after the descriptor's last byte is accepted. A link rewritten while that descriptor's bytes are streaming takes effect.
- R8: A link may point to the same descriptor or to an earlier one. The walker then loops without end, and a rewritten link in the loop redirects it.
- R9: Finishing a descriptor with the end-of-frame flag set sets `irq_status` and loads `eof_desc_addr` with that descriptor's address. Descriptors with the flag clear change neither.
- R10: `irq` is high exactly when `irq_status` and `irq_en` are both high.
- R11: `irq_status` stays set until a `irq_clr` pulse. After that pulse it reads 0 the following cycle, unless a new end-of-frame completion lands in the same cycle.
- R12: A stop pulse returns the walker to idle. The next cycle `out_valid` and `busy` are 0, and no memory read follows until the next start. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk at `start_addr` (honoured in idle only) |
| start_addr | input | AW | First descriptor address |
| stop | input | 1 | Abandon the walk and go idle |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | AW | Word-aligned byte address of the read |
| mem_rdata | input | DW | Read data, valid the cycle after `mem_rd` |
| out_valid | output | 1 | Byte available |
| out_ready | input | 1 | Downstream accepts the byte |
| out_data | output | 8 | Streamed byte |
| busy | output | 1 | Walker not idle |
| irq_en | input | 1 | End-of-frame interrupt enable |
| irq_clr | input | 1 | Clears the end-of-frame status |
| irq_status | output | 1 | Sticky end-of-frame status |
| eof_desc_addr | output | AW | Address of the last completed end-of-frame descriptor |
| irq | output | 1 | Gated interrupt |

## Verification
The bench builds the walker with the defaults AW = 32 and DW = 32, over a 1 KiB word memory. It places descriptors and buffers at unaligned byte offsets, so every byte lane and the mid-word refetch path get exercised. Zero-length descriptors, self-loops and back-links between a pair fit in that space, and each pass of an empty loop takes only five cycles. That lets the bench rewrite links mid-stream and redirect an idle loop within a few hundred cycles. The bench also sees the exact sequence of captured end-of-frame addresses.

// File: rtl/chain_walker_pkg.sv
package chain_walker_pkg;

    // Control word field positions; the walker decodes only these two.
    localparam int CTL_LEN_LSB = 12;
    localparam int CTL_LEN_W   = 12;
    localparam int CTL_EOF_BIT = 30;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL_RD,
        ST_CTRL_TAKE,
        ST_BUF_TAKE,
        ST_WORD_RD,
        ST_WORD_TAKE,
        ST_SEND,
        ST_LINK_RD,
        ST_LINK_TAKE
    } walk_state_t;

    function automatic logic [CTL_LEN_W-1:0] ctl_len(input logic [31:0] w);
        return w[CTL_LEN_LSB +: CTL_LEN_W];
    endfunction

    function automatic logic ctl_eof(input logic [31:0] w);
        return w[CTL_EOF_BIT];
    endfunction

endpackage

// File: rtl/chain_walker_seq.sv
module chain_walker_seq
    import chain_walker_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start,
    input  logic [AW-1:0]                     start_addr,
    input  logic                              stop,
    output logic                              mem_rd,
    output logic [AW-1:0]                     mem_addr,
    input  logic [DW-1:0]                     mem_rdata,
    output logic                              out_valid,
    input  logic                              out_ready,
    output logic                              word_load,
    output logic [$clog2(DW/8)-1:0]           lane_sel,
    output logic                              busy,
    output logic                              eof_done,
    output logic [AW-1:0]                     done_addr
);
    localparam int            LANE_W = $clog2(DW/8);
    localparam logic [AW-1:0] WORD_B = AW'(DW/8);
    localparam logic [LANE_W-1:0] LANE_TOP = {LANE_W{1'b1}};

    walk_state_t          state_q, state_d;
    logic [AW-1:0]        desc_q;
    logic [AW-1:0]        ptr_q;
    logic [CTL_LEN_W-1:0] left_q;
    logic                 eof_q;
    logic [AW-1:0]        desc_base;
    logic                 fire;
    logic [31:0]          ctl_word;
    logic [DW-33:0]       rdata_unused;

    assign desc_base    = {desc_q[AW-1:LANE_W], {LANE_W{1'b0}}};
    assign fire         = out_valid & out_ready;
    assign ctl_word     = mem_rdata[31:0];
    assign rdata_unused = '0;

    // State register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            desc_q  <= '0;
            ptr_q   <= '0;
            left_q  <= '0;
            eof_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: begin
                    if (start && !stop) desc_q <= start_addr;
                end
                ST_CTRL_TAKE: begin
                    left_q <= ctl_len(ctl_word);
                    eof_q  <= ctl_eof(ctl_word);
                end
                ST_BUF_TAKE: begin
                    ptr_q <= mem_rdata[AW-1:0];
                end
                ST_SEND: begin
                    if (fire) begin
                        ptr_q  <= ptr_q + 1'b1;
                        left_q <= left_q - 1'b1;
                    end
                end
                ST_LINK_TAKE: begin
                    desc_q <= mem_rdata[AW-1:0];
                end
                default: ;
            endcase
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (stop && state_q != ST_IDLE) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:      if (start && !stop) state_d = ST_CTRL_RD;
                ST_CTRL_RD:   state_d = ST_CTRL_TAKE;
                ST_CTRL_TAKE: state_d = ST_BUF_TAKE;
                ST_BUF_TAKE:  state_d = (left_q == '0) ? ST_LINK_RD : ST_WORD_RD;
                ST_WORD_RD:   state_d = ST_WORD_TAKE;
                ST_WORD_TAKE: state_d = ST_SEND;
                ST_SEND: begin
                    if (fire) begin
                        if (left_q == CTL_LEN_W'(1))
                            state_d = ST_LINK_RD;
                        else if (ptr_q[LANE_W-1:0] == LANE_TOP)
                            state_d = ST_WORD_RD;
                    end
                end
                ST_LINK_RD:   state_d = ST_LINK_TAKE;
                ST_LINK_TAKE: state_d = ST_CTRL_RD;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_rd    = 1'b0;
        mem_addr  = '0;
        out_valid = 1'b0;
        word_load = 1'b0;
        eof_done  = 1'b0;
        unique case (state_q)
            ST_CTRL_RD: begin
                mem_rd   = 1'b1;
                mem_addr = desc_base;
            end
            ST_CTRL_TAKE: begin
                mem_rd   = 1'b1;
                mem_addr = desc_base + WORD_B;
            end
            ST_WORD_RD: begin
                mem_rd   = 1'b1;
                mem_addr = {ptr_q[AW-1:LANE_W], {LANE_W{1'b0}}};
            end
            ST_WORD_TAKE: word_load = 1'b1;
            ST_SEND:      out_valid = 1'b1;
            ST_LINK_RD: begin
                mem_rd   = 1'b1;
                mem_addr = desc_base + (WORD_B << 1);
            end
            ST_LINK_TAKE: eof_done = eof_q && !stop;
            default: ;
        endcase
    end

    assign busy      = (state_q != ST_IDLE);
    assign lane_sel  = ptr_q[LANE_W-1:0];
    assign done_addr = desc_base;

endmodule

// File: rtl/chain_walker_lane.sv
module chain_walker_lane #(
    parameter int DW = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    word_load,
    input  logic [DW-1:0]           mem_rdata,
    input  logic [$clog2(DW/8)-1:0] lane_sel,
    output logic [7:0]              out_data
);
    localparam int NB = DW / 8;

    logic [DW-1:0] word_q;
    logic [7:0]    lanes [NB];

    always_ff @(posedge clk) begin
        if (!rst_n)         word_q <= '0;
        else if (word_load) word_q <= mem_rdata;
    end

    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign lanes[g] = word_q[8*g +: 8];
    end

    assign out_data = lanes[lane_sel];

endmodule

// File: rtl/chain_walker_irq.sv
module chain_walker_irq #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          eof_done,
    input  logic [AW-1:0] done_addr,
    input  logic          irq_en,
    input  logic          irq_clr,
    output logic          irq_status,
    output logic [AW-1:0] eof_desc_addr,
    output logic          irq
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_status    <= 1'b0;
            eof_desc_addr <= '0;
        end else if (eof_done) begin
            irq_status    <= 1'b1;
            eof_desc_addr <= done_addr;
        end else if (irq_clr) begin
            irq_status    <= 1'b0;
        end
    end

    assign irq = irq_status & irq_en;

endmodule

// File: rtl/chain_walker.sv
module chain_walker #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic          stop,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [7:0]    out_data,
    output logic          busy,
    input  logic          irq_en,
    input  logic          irq_clr,
    output logic          irq_status,
    output logic [AW-1:0] eof_desc_addr,
    output logic          irq
);
    localparam int LANE_W = $clog2(DW/8);

    logic              word_load;
    logic [LANE_W-1:0] lane_sel;
    logic              eof_done;
    logic [AW-1:0]     done_addr;

    chain_walker_seq #(.AW(AW), .DW(DW)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_addr (start_addr),
        .stop       (stop),
        .mem_rd     (mem_rd),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .word_load  (word_load),
        .lane_sel   (lane_sel),
        .busy       (busy),
        .eof_done   (eof_done),
        .done_addr  (done_addr)
    );

    chain_walker_lane #(.DW(DW)) lane_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_load (word_load),
        .mem_rdata (mem_rdata),
        .lane_sel  (lane_sel),
        .out_data  (out_data)
    );

    chain_walker_irq #(.AW(AW)) irq_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .eof_done      (eof_done),
        .done_addr     (done_addr),
        .irq_en        (irq_en),
        .irq_clr       (irq_clr),
        .irq_status    (irq_status),
        .eof_desc_addr (eof_desc_addr),
        .irq           (irq)
    );

endmodule

// File: rtl/chain_walker_chk.sv
module chain_walker_chk #(
    parameter int AW     = 32,
    parameter int LANE_W = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [AW-1:0] start_addr,
    input logic          stop,
    input logic          busy,
    input logic          out_valid,
    input logic          out_ready,
    input logic [7:0]    out_data,
    input logic          mem_rd,
    input logic [AW-1:0] mem_addr,
    input logic          irq_status,
    input logic          irq_clr,
    input logic          eof_done
);
    // R5: a stalled byte holds
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && !stop |=> out_valid && $stable(out_data));

    // R12: stop leaves the walker idle with no byte offered
    p_stop_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !out_valid && !busy);

    // R12: idle walker neither reads nor offers data
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !out_valid && !mem_rd);

    // R11: status is sticky without a clear
    p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_status && !irq_clr |=> irq_status);

    // R11: clear with no concurrent completion empties the status
    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr && !eof_done |=> !irq_status);

    // R2: first read after start targets the control word
    p_first_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && !stop |=> mem_rd &&
        (mem_addr[AW-1:LANE_W] == $past(start_addr[AW-1:LANE_W])));
endmodule

bind chain_walker chain_walker_chk #(.AW(AW), .LANE_W(LANE_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_addr (start_addr),
    .stop       (stop),
    .busy       (busy),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .mem_rd     (mem_rd),
    .mem_addr   (mem_addr),
    .irq_status (irq_status),
    .irq_clr    (irq_clr),
    .eof_done   (eof_done)
);

// File: tb/chain_walker_tb_top.sv
module chain_walker_tb_top;
    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic          stop = 1'b0;
    logic          mem_rd;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [7:0]    out_data;
    logic          busy;
    logic          irq_en = 1'b0;
    logic          irq_clr = 1'b0;
    logic          irq_status;
    logic [AW-1:0] eof_desc_addr;
    logic          irq;

    always #2 clk = ~clk;

    chain_walker #(.AW(AW), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .stop(stop),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .busy(busy),
        .irq_en(irq_en), .irq_clr(irq_clr), .irq_status(irq_status),
        .eof_desc_addr(eof_desc_addr), .irq(irq)
    );

    // Synchronous memory model, 256 words
    logic [31:0] mem [0:255];
    always_ff @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[9:2]];

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0]  exp_q [$];
    logic [31:0] eof_log [$];
    logic [31:0] last_eof = '0;
    logic [31:0] rd_log [$];
    bit          rd_arm = 0;
    int          rx_cnt = 0;
    bit          watch_rd = 0;
    int          stray_rd = 0;
    int          stray_vld = 0;
    bit          rdy_low = 0;
    bit          hold_pend = 0;
    logic [7:0]  hold_data = '0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_byte(input int a, input logic [7:0] v);
        mem[a >> 2][8*(a % 4) +: 8] = v;
    endtask

    task automatic put_desc(input int a, input int len, input bit eof, input bit junk,
                            input int bufp, input int link);
        logic [31:0] c;
        c = 32'(len) << 12;
        c[30] = eof;
        if (junk) c = c | 32'hBF00_0ABC;
        mem[a >> 2]       = c;
        mem[(a >> 2) + 1] = 32'(bufp);
        mem[(a >> 2) + 2] = 32'(link);
    endtask

    task automatic fill_buf(input int bufp, input int len, input bit push);
        for (int i = 0; i < len; i++) begin
            logic [7:0] v;
            v = 8'((bufp + i) * 7) ^ 8'h5A;
            wr_byte(bufp + i, v);
            if (push) exp_q.push_back(v);
        end
    endtask

    task automatic pulse_start(input int a);
        @(posedge clk); #1; start = 1'b1; start_addr = 32'(a);
        @(posedge clk); #1; start = 1'b0;
    endtask

    task automatic pulse_stop();
        @(posedge clk); #1; stop = 1'b1;
        @(posedge clk); #1; stop = 1'b0;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    // Ready pattern generator
    initial begin
        int cyc;
        cyc = 0;
        forever begin
            @(posedge clk); #1;
            cyc++;
            out_ready = !rdy_low && (cyc % 4 != 1) && (cyc % 7 != 3);
        end
    end

    // Monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (hold_pend)
                    check(out_valid && out_data == hold_data, "R5 stalled byte held",
                          {23'd0, out_valid, out_data}, {24'd1, hold_data});
                hold_pend = out_valid && !out_ready && !stop;
                hold_data = out_data;
                if (out_valid && out_ready) begin
                    rx_cnt++;
                    if (exp_q.size() == 0) begin
                        check(0, "R4 unexpected byte", 32'(out_data), 32'hFFFF_FFFF);
                    end else begin
                        logic [7:0] e;
                        e = exp_q.pop_front();
                        check(out_data == e, "R4 byte order/value", 32'(out_data), 32'(e));
                    end
                end
                if (eof_desc_addr != last_eof) begin
                    eof_log.push_back(eof_desc_addr);
                    last_eof = eof_desc_addr;
                end
                if (mem_rd && rd_arm && rd_log.size() < 3) rd_log.push_back(mem_addr);
                if (mem_rd && watch_rd) stray_rd++;
                if (out_valid && watch_rd) stray_vld++;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired act=hung exp=done");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        // Chain: D0(0x00) -> D1(0x10, len 0) -> D2(0x20, eof) -> idle pair D3/D4
        put_desc(32'h000, 5, 0, 0, 32'h101, 32'h010);
        put_desc(32'h010, 0, 0, 0, 32'h000, 32'h020);
        put_desc(32'h020, 9, 1, 1, 32'h140, 32'h060);   // link fixed during streaming (R7)
        put_desc(32'h030, 0, 1, 0, 32'h000, 32'h040);
        put_desc(32'h040, 0, 0, 0, 32'h000, 32'h030);
        put_desc(32'h050, 3, 1, 0, 32'h183, 32'h030);
        put_desc(32'h060, 4, 1, 0, 32'h1C0, 32'h030);   // must never run
        put_desc(32'h070, 40, 0, 0, 32'h200, 32'h030);
        fill_buf(32'h101, 5, 1);
        fill_buf(32'h140, 9, 1);
        fill_buf(32'h1C0, 4, 0);

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!busy && !out_valid && !mem_rd, "R1 idle after reset",
              {29'd0, busy, out_valid, mem_rd}, 32'd0);
        check(!irq_status && !irq && eof_desc_addr == 0, "R1 status clear after reset",
              eof_desc_addr | 32'(irq_status), 32'd0);

        irq_en = 1'b1;
        rd_arm = 1;
        pulse_start(32'h000);
        while (rx_cnt < 6) @(negedge clk);
        // R7: rewrite D2 link while D2 is streaming
        @(posedge clk); #1; mem[(32'h020 >> 2) + 2] = 32'h030;
        check(rd_log.size() == 3 && rd_log[0] == 32'h000, "R2 control word read first",
              rd_log[0], 32'h000);
        check(rd_log[1] == 32'h004, "R2 buffer pointer read second", rd_log[1], 32'h004);
        check(rd_log[2] == 32'h100, "R4 aligned word fetch for unaligned buffer", rd_log[2], 32'h100);

        while (eof_log.size() < 2) @(negedge clk);
        // R12: start while busy is ignored (0x60 bytes would be unexpected)
        pulse_start(32'h060);
        repeat (60) @(negedge clk);
        check(rx_cnt == 14, "R3 R6 byte count of first chain", 32'(rx_cnt), 32'd14);
        check(exp_q.size() == 0, "R4 all expected bytes seen", 32'(exp_q.size()), 32'd0);
        check(eof_log[0] == 32'h020, "R9 eof address of D2", eof_log[0], 32'h020);
        check(eof_log[1] == 32'h030, "R7 rewritten link followed to idle loop", eof_log[1], 32'h030);
        check(eof_log.size() == 2, "R8 idle loop keeps captured address", 32'(eof_log.size()), 32'd2);

        // R8: redirect idle loop
        @(posedge clk); #1;
        fill_buf(32'h183, 3, 1);
        mem[(32'h040 >> 2) + 2] = 32'h050;
        while (eof_log.size() < 4) @(negedge clk);
        check(eof_log[2] == 32'h050, "R8 redirected loop reaches new descriptor", eof_log[2], 32'h050);
        check(eof_log[3] == 32'h030, "R8 back-link returns to loop", eof_log[3], 32'h030);
        check(rx_cnt == 17, "R4 redirected bytes delivered", 32'(rx_cnt), 32'd17);

        // R10 gating
        @(posedge clk); #1; irq_en = 1'b0;
        @(negedge clk);
        check(irq_status && !irq, "R10 irq masked", {30'd0, irq_status, irq}, 32'd2);
        @(posedge clk); #1; irq_en = 1'b1;
        @(negedge clk);
        check(irq_status && irq, "R10 irq enabled", {30'd0, irq_status, irq}, 32'd3);

        // R12 stop, R11 sticky and clear
        pulse_stop();
        watch_rd = 1;
        @(negedge clk);
        check(!busy && !out_valid, "R12 idle after stop", {30'd0, busy, out_valid}, 32'd0);
        check(irq_status, "R11 status sticky", 32'(irq_status), 32'd1);
        @(posedge clk); #1; irq_clr = 1'b1;
        @(posedge clk); #1; irq_clr = 1'b0;
        @(negedge clk);
        check(!irq_status && !irq, "R11 clear empties status", {30'd0, irq_status, irq}, 32'd0);
        repeat (30) @(negedge clk);
        check(stray_rd == 0 && stray_vld == 0, "R12 no activity after stop",
              32'(stray_rd + stray_vld), 32'd0);
        watch_rd = 0;

        // R12 stop in mid-stream with a stalled byte
        @(posedge clk); #1; fill_buf(32'h200, 40, 1);
        pulse_start(32'h070);
        while (rx_cnt < 27) @(negedge clk);
        @(posedge clk); #1; rdy_low = 1;
        repeat (4) @(posedge clk);
        #1 stop = 1'b1;
        @(posedge clk); #1; stop = 1'b0; exp_q.delete(); watch_rd = 1; stray_rd = 0; stray_vld = 0;
        @(negedge clk);
        check(!busy && !out_valid, "R12 stop drops valid mid-stream", {30'd0, busy, out_valid}, 32'd0);
        rdy_low = 0;
        repeat (20) @(negedge clk);
        check(stray_rd == 0 && stray_vld == 0, "R12 stays idle after mid-stream stop",
              32'(stray_rd + stray_vld), 32'd0);

        summary();
        $finish;
    end
endmodule